// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block holds the combinational hazard decisions of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Its first part looks at the two source register numbers of the instruction now executing. It compares them with the destination registers of the two older instructions still in flight. From that it produces one operand-source select per ALU input, which steers the datapath multiplexer to one of three places: the register-file read value, the result held after execute, or the result held after memory access. The newest matching producer always wins.

The second part guards the one case forwarding cannot cover. A load in execute delivers its data only after the memory stage, so a dependent instruction right behind it in decode must wait one cycle. When that happens the unit drops the program-counter and fetch/decode register enables, so the next instruction is fetched again, and it raises a bubble signal that zeroes every control bit entering execute. After the single bubble, the loaded value reaches the dependent instruction through the write-back forwarding path. A taken branch raises a fetch/decode flush, and it also overrides the interlock so the redirect can proceed.

Top module: `hazard_unit`

## Requirements
- R1: Each operand select uses the encoding 2'b00 = register-file value, 2'b10 = result after execute, 2'b01 = result after memory; 2'b11 is never produced, and 2'b00 is produced when no producer qualifies.
- R2: An operand select is 2'b10 when `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals that operand's source register.
- R3: An operand select is 2'b01 when `wb_wr` is 1, `wb_dst` is nonzero, `wb_dst` equals the source register, and the R2 condition does not hold.
- R4: When both older producers qualify for the same source register, the select is 2'b10 (the newer result wins).
- R5: Register 0 is never forwarded: a source of 0 always gives select 2'b00.
- R6: A producer whose write flag is 0 is ignored, whatever its destination number.
- R7: A load-use hazard exists when `ex_is_load` is 1 and `ex_src_b` (the load's destination) equals `id_src_a` or `id_src_b`, register 0 included.
- R8: On a load-use hazard with `br_taken` at 0: `pc_en` = 0, `ifid_en` = 0, `bubble` = 1, `ifid_flush` = 0.
- R9: With no hazard and no taken branch: `pc_en` = 1, `ifid_en` = 1, `bubble` = 0, `ifid_flush` = 0.
- R10: When `br_taken` is 1: `ifid_flush` = 1, `bubble` = 1, `pc_en` = 1 and `ifid_en` = 1, whether or not a load-use hazard is present.
- R11: The A and B selects are decided independently, each from its own source register (`ex_src_a`, `ex_src_b`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | AW | First source register of the instruction in execute |
| ex_src_b | input | AW | Second source register of the instruction in execute (destination when it is a load) |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| mem_dst | input | AW | Destination register of the instruction after execute |
| mem_wr | input | 1 | Instruction after execute writes the register file |
| wb_dst | input | AW | Destination register of the instruction after memory |
| wb_wr | input | 1 | Instruction after memory writes the register file |
| id_src_a | input | AW | First source register of the instruction in decode |
| id_src_b | input | AW | Second source register of the instruction in decode |
| br_taken | input | 1 | Branch resolved as taken this cycle |
| sel_a | output | 2 | Operand-source select for ALU input A |
| sel_b | output | 2 | Operand-source select for ALU input B |
| pc_en | output | 1 | Program counter may update |
| ifid_en | output | 1 | Fetch/decode register may load |
| bubble | output | 1 | Zero all control bits entering execute |
| ifid_flush | output | 1 | Load a nop into the fetch/decode register |

## Verification
The two functions that can coincide are the load-use interlock and the taken-branch flush. The bench provokes this by sweeping every combination of decode sources, load destination and load flag with `br_taken` both low and high. It then judges the four pipeline controls against R8 and R10, expecting the flush to release the freeze. Forwarding is also judged through a modelled operand multiplexer, which must deliver the value of the newest write to the source register over every small configuration.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic pc_en;
        logic ifid_en;
        logic bubble;
        logic flush;
    } pipe_ctl_t;

    localparam int NUM_OPND = 2;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output opnd_src_e     pick
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wr && (mem_dst != ZERO_REG) && (mem_dst == src);
        wb_hit  = wb_wr && (wb_dst != ZERO_REG) && (wb_dst == src);
        // the younger producer shadows the older one
        if (mem_hit) begin
            pick = SRC_MEM;
        end else if (wb_hit) begin
            pick = SRC_WB;
        end else begin
            pick = SRC_RF;
        end
    end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] load_dst,
    input  logic          is_load,
    output logic          hazard
);

    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_a  = (load_dst == id_src_a);
        hit_b  = (load_dst == id_src_b);
        hazard = is_load && (hit_a || hit_b);
    end

endmodule

// File: rtl/hz_ctrl_gate.sv
module hz_ctrl_gate
    import hz_pkg::*;
(
    input  logic      hazard,
    input  logic      br_taken,
    output pipe_ctl_t ctl
);

    logic freeze;

    always_comb begin
        // a redirect discards the waiting instruction, so it releases the freeze
        freeze      = hazard && !br_taken;
        ctl.pc_en   = !freeze;
        ctl.ifid_en = !freeze;
        ctl.bubble  = hazard || br_taken;
        ctl.flush   = br_taken;
    end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic          br_taken,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic          pc_en,
    output logic          ifid_en,
    output logic          bubble,
    output logic          ifid_flush
);

    logic [AW-1:0] ex_src [NUM_OPND];
    opnd_src_e     pick   [NUM_OPND];
    logic          hazard;
    pipe_ctl_t     ctl;

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hz_fwd_pick #(.AW(AW)) i_pick (
            .src     (ex_src[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .pick    (pick[g])
        );
    end

    hz_load_use #(.AW(AW)) i_load_use (
        .id_src_a (id_src_a),
        .id_src_b (id_src_b),
        .load_dst (ex_src_b),
        .is_load  (ex_is_load),
        .hazard   (hazard)
    );

    hz_ctrl_gate i_ctrl_gate (
        .hazard   (hazard),
        .br_taken (br_taken),
        .ctl      (ctl)
    );

    always_comb begin
        sel_a      = pick[0];
        sel_b      = pick[1];
        pc_en      = ctl.pc_en;
        ifid_en    = ctl.ifid_en;
        bubble     = ctl.bubble;
        ifid_flush = ctl.flush;
    end

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ex_src_a,
    input logic [AW-1:0] ex_src_b,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_dst,
    input logic          mem_wr,
    input logic [AW-1:0] wb_dst,
    input logic          wb_wr,
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic          br_taken,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic          pc_en,
    input logic          ifid_en,
    input logic          bubble,
    input logic          ifid_flush
);

    always_comb begin
        AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11); // R1
        AST_ZERO_SRC: assert ((ex_src_a != '0 || sel_a == 2'b00) && (ex_src_b != '0 || sel_b == 2'b00)); // R5
        AST_IDLE_PRODUCERS: assert ((mem_wr || wb_wr) || (sel_a == 2'b00 && sel_b == 2'b00)); // R6
        AST_NEWER_WINS: assert (!(mem_wr && mem_dst != '0 && mem_dst == ex_src_a) || sel_a == 2'b10); // R4
        AST_FREEZE_PAIR: assert (pc_en == ifid_en); // R8
        AST_FREEZE_BUBBLE: assert (pc_en || (bubble && !ifid_flush)); // R8
        AST_FLUSH_RELEASES: assert (!br_taken || (pc_en && ifid_en && bubble && ifid_flush)); // R10
        AST_LOAD_REQUIRED: assert (ex_is_load || br_taken || (pc_en && !bubble)); // R9
    end

endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) i_hazard_unit_chk (.*);

// File: tb/test_hazard_unit.sv
module test_hazard_unit;

    localparam int AW = 2;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, id_src_a, id_src_b;
    logic          ex_is_load, mem_wr, wb_wr, br_taken;
    logic [1:0]    sel_a, sel_b;
    logic          pc_en, ifid_en, bubble, ifid_flush;

    int n_checks = 0;
    int n_errors = 0;

    hazard_unit #(.AW(AW)) i_hazard_unit (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .br_taken(br_taken),
        .sel_a(sel_a), .sel_b(sel_b), .pc_en(pc_en), .ifid_en(ifid_en),
        .bubble(bubble), .ifid_flush(ifid_flush)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected select from the requirements: newest qualifying writer
    function automatic int exp_sel(int src, int md, int mw, int wd, int ww);
        if (src == 0) return 0;                       // R5
        if (mw != 0 && md == src) return 2;           // R2, R4
        if (ww != 0 && wd == src) return 1;           // R3
        return 0;                                     // R1, R6
    endfunction

    // modelled operand multiplexer: register file holds 100+r, results 200/300
    function automatic int mux_val(int sel, int src);
        case (sel)
            2: return 200;
            1: return 300;
            default: return 100 + src;
        endcase
    endfunction

    // architectural value: replay the writes oldest first
    function automatic int arch_val(int src, int md, int mw, int wd, int ww);
        int v = 100 + src;
        if (src != 0 && ww != 0 && wd == src) v = 300;
        if (src != 0 && mw != 0 && md == src) v = 200;
        return v;
    endfunction

    function automatic string fwd_tag(int src, int md, int mw, int wd, int ww);
        if (src == 0) return "R5";
        if (mw != 0 && md == src && ww != 0 && wd == src) return "R4";
        if (mw != 0 && md == src) return "R2";
        if (ww != 0 && wd == src) return "R3";
        if ((md == src) || (wd == src)) return "R6";
        return "R1";
    endfunction

    initial begin
        ex_src_a = '0; ex_src_b = '0; ex_is_load = 1'b0;
        mem_dst = '0; mem_wr = 1'b0; wb_dst = '0; wb_wr = 1'b0;
        id_src_a = '0; id_src_b = '0; br_taken = 1'b0;
        @(negedge clk);
        #1;
        // idle state
        check("R1 idle sel_a", int'(sel_a), 0);
        check("R1 idle sel_b", int'(sel_b), 0);
        check("R9 idle pc_en", int'(pc_en), 1);
        check("R9 idle ifid_en", int'(ifid_en), 1);
        check("R9 idle bubble", int'(bubble), 0);
        check("R9 idle ifid_flush", int'(ifid_flush), 0);

        // forwarding sweep over every small configuration
        for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
        for (int md = 0; md < NR; md++)
        for (int wd = 0; wd < NR; wd++)
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            ex_src_a = AW'(a); ex_src_b = AW'(b);
            mem_dst = AW'(md); wb_dst = AW'(wd);
            mem_wr = w[1]; wb_wr = w[0];
            #1;
            check({fwd_tag(a, md, w[1], wd, w[0]), " R11 sel_a"}, int'(sel_a),
                  exp_sel(a, md, w[1], wd, w[0]));
            check({fwd_tag(b, md, w[1], wd, w[0]), " R11 sel_b"}, int'(sel_b),
                  exp_sel(b, md, w[1], wd, w[0]));
            check({fwd_tag(a, md, w[1], wd, w[0]), " operand A value"},
                  mux_val(int'(sel_a), a), arch_val(a, md, w[1], wd, w[0]));
            check({fwd_tag(b, md, w[1], wd, w[0]), " operand B value"},
                  mux_val(int'(sel_b), b), arch_val(b, md, w[1], wd, w[0]));
        end

        mem_wr = 1'b0; wb_wr = 1'b0; ex_src_a = '0;

        // interlock and flush sweep, including both at once
        for (int ia = 0; ia < NR; ia++)
        for (int ib = 0; ib < NR; ib++)
        for (int ld = 0; ld < NR; ld++)
        for (int f = 0; f < 4; f++) begin
            int hz;
            int frz;
            @(negedge clk);
            id_src_a = AW'(ia); id_src_b = AW'(ib); ex_src_b = AW'(ld);
            ex_is_load = f[1]; br_taken = f[0];
            #1;
            hz  = (f[1] != 0 && (ld == ia || ld == ib)) ? 1 : 0;   // R7
            frz = (hz != 0 && f[0] == 0) ? 1 : 0;
            if (f[0] != 0) begin
                check("R10 pc_en", int'(pc_en), 1);
                check("R10 ifid_en", int'(ifid_en), 1);
                check("R10 bubble", int'(bubble), 1);
                check("R10 ifid_flush", int'(ifid_flush), 1);
            end else if (frz != 0) begin
                check("R7 R8 pc_en", int'(pc_en), 0);
                check("R8 ifid_en", int'(ifid_en), 0);
                check("R8 bubble", int'(bubble), 1);
                check("R8 ifid_flush", int'(ifid_flush), 0);
            end else begin
                check("R7 R9 pc_en", int'(pc_en), 1);
                check("R9 ifid_en", int'(ifid_en), 1);
                check("R9 bubble", int'(bubble), 0);
                check("R9 ifid_flush", int'(ifid_flush), 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule